// File: doc/BRIEF.md
# RS-485 Driver Turnaround Timer

This block steers the direction line of an external half-duplex RS-485 transceiver that sits behind a UART transmitter. While the transmit shift register holds a frame, the direction line stays high and the transceiver drives the bus. After the last bit of the final frame has left the register, the block counts a programmed number of whole bit periods. It then pulls the direction line low, which turns the transceiver around to receive.

The serializer reports activity on `txBusy`. The baud-rate divisor supplies one `baudTick` pulse per oversampling tick. A 2-bit rate field sets how many ticks make one bit period. The line can be routed to either of two modem-control outputs. The output that is not selected is held high.

Top module: `rs485_dir_timer`

## Requirements
- R1: After reset the selected direction output is 0 (receive) and the unselected output is 1.
- R2: The clock edge that samples `txBusy` high sets the selected output to 1. The output stays 1 for as long as `txBusy` stays high.
- R3: The countdown begins at the first edge that samples `txBusy` low after a busy period. The output stays 1 until the countdown has counted rate × max(`delayBits`,1) `baudTick` pulses. The output goes to 0 at the edge that samples the final pulse.
- R4: The rate field `sampleSel` encodes the oversampling factor as 00 = 16 ticks per bit, 01 = 8 and 10 = 4.
- R5: The reserved code 11 on `sampleSel` behaves like 00 (16 ticks per bit).
- R6: A `delayBits` value of 0 turns the line around at the end of the first bit period, the same as a value of 1.
- R7: If `txBusy` goes high again during a countdown, that countdown is abandoned and the output stays 1. A complete new countdown starts when `txBusy` falls again.
- R8: When `useDtr` is 1 the direction appears on `dtrOut` and `rtsOut` is held at 1. When `useDtr` is 0 the direction appears on `rtsOut` and `dtrOut` is held at 1.
- R9: The selected output falls only at an edge that sampled `baudTick` high and `txBusy` low.
- R10: `sampleSel` and `delayBits` are captured when a countdown begins. Changing them during the countdown does not change its length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| baudTick | input | 1 | One-cycle oversampling tick from the baud divisor |
| txBusy | input | 1 | High while a frame is loaded into or shifting out of the transmit shift register |
| sampleSel | input | 2 | Oversampling rate code |
| delayBits | input | 8 | Turnaround delay in bit periods |
| useDtr | input | 1 | Selects DTR (1) or RTS (0) as the direction output |
| rtsOut | output | 1 | RTS pin level |
| dtrOut | output | 1 | DTR pin level |

## Verification
The hardest case to reach is a new frame that arrives part of the way through a countdown, at a point where some ticks of the current bit period have already been counted. In that case the countdown must restart from nothing and not resume. The stimulus drops `txBusy` and feeds ticks at an uneven spacing. It then raises `txBusy` in the middle of a bit period and later measures the full fresh tick count. In a similar way, the bench rewrites the rate and delay settings in the middle of a countdown to show that the values captured at the start are the ones used. Each rate code and delay value of zero is measured as an exact tick count from the fall of `txBusy` to the fall of the direction output.

// File: rtl/rs485_dir_pkg.sv
package rs485_dir_pkg;

  typedef enum logic [1:0] {
    DIR_RECV  = 2'd0,
    DIR_DRIVE = 2'd1,
    DIR_HOLD  = 2'd2
  } dirState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic startWait;  // capture settings, clear counters
    logic runWait;    // countdown active this cycle
  } dirStrobe_t;

  // last tick index of one bit period for a rate code
  function automatic logic [3:0] tickLimit(input logic [1:0] code);
    case (code)
      2'b01:   return 4'd7;
      2'b10:   return 4'd3;
      default: return 4'd15;  // 00 and reserved 11
    endcase
  endfunction

endpackage

// File: rtl/rs485_dir_ctrl.sv
module rs485_dir_ctrl
  import rs485_dir_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       txBusy,
  input  logic       periodDone,
  output dirStrobe_t strobe,
  output logic       driveLine
);

  dirState_t state, stateNext;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    case (state)
      DIR_RECV:  if (txBusy) stateNext = DIR_DRIVE;
      DIR_DRIVE: if (!txBusy) begin
        stateNext        = DIR_HOLD;
        strobe.startWait = 1'b1;
      end
      DIR_HOLD: begin
        if (txBusy) begin
          stateNext = DIR_DRIVE;
        end else begin
          strobe.runWait = 1'b1;
          if (periodDone) stateNext = DIR_RECV;
        end
      end
      default: stateNext = DIR_RECV;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= DIR_RECV;
    else       state <= stateNext;
  end

  assign driveLine = (state != DIR_RECV);

endmodule

// File: rtl/rs485_dir_datapath.sv
module rs485_dir_datapath
  import rs485_dir_pkg::*;
#(
  parameter int DELAY_W = 8,
  parameter int TICK_W  = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               baudTick,
  input  logic [1:0]         sampleSel,
  input  logic [DELAY_W-1:0] delayBits,
  input  dirStrobe_t         strobe,
  output logic               periodDone
);

  localparam logic [DELAY_W-1:0] ONE_BIT = DELAY_W'(1);

  logic [TICK_W-1:0]  tickCnt;
  logic [TICK_W-1:0]  tickTop;
  logic [DELAY_W-1:0] bitsLeft;
  logic               bitEdge;

  assign bitEdge    = strobe.runWait && baudTick && (tickCnt == tickTop);
  assign periodDone = bitEdge && (bitsLeft == ONE_BIT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt  <= '0;
      tickTop  <= '0;
      bitsLeft <= '0;
    end else if (strobe.startWait) begin
      tickCnt  <= '0;
      tickTop  <= TICK_W'(tickLimit(sampleSel));
      bitsLeft <= (delayBits == '0) ? ONE_BIT : delayBits;
    end else if (strobe.runWait && baudTick) begin
      if (bitEdge) begin
        tickCnt  <= '0;
        bitsLeft <= bitsLeft - ONE_BIT;
      end else begin
        tickCnt <= tickCnt + TICK_W'(1);
      end
    end
  end

endmodule

// File: rtl/rs485_dir_timer.sv
module rs485_dir_timer
  import rs485_dir_pkg::*;
#(
  parameter int DELAY_W = 8,
  parameter int TICK_W  = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               baudTick,
  input  logic               txBusy,
  input  logic [1:0]         sampleSel,
  input  logic [DELAY_W-1:0] delayBits,
  input  logic               useDtr,
  output logic               rtsOut,
  output logic               dtrOut
);

  dirStrobe_t strobe;
  logic       periodDone;
  logic       driveLine;

  rs485_dir_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .txBusy    (txBusy),
    .periodDone(periodDone),
    .strobe    (strobe),
    .driveLine (driveLine)
  );

  rs485_dir_datapath #(
    .DELAY_W(DELAY_W),
    .TICK_W (TICK_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .baudTick  (baudTick),
    .sampleSel (sampleSel),
    .delayBits (delayBits),
    .strobe    (strobe),
    .periodDone(periodDone)
  );

  // unselected pin parks high
  assign rtsOut = useDtr ? 1'b1 : driveLine;
  assign dtrOut = useDtr ? driveLine : 1'b1;

endmodule

// File: rtl/rs485_dir_timer_chk.sv
module rs485_dir_timer_chk (
  input logic clk,
  input logic rstN,
  input logic baudTick,
  input logic txBusy,
  input logic useDtr,
  input logic rtsOut,
  input logic dtrOut
);

  logic selPin;
  logic idlePin;
  assign selPin  = useDtr ? dtrOut : rtsOut;
  assign idlePin = useDtr ? rtsOut : dtrOut;

  // R1
  reset_recv_chk: assert property (@(posedge clk) !rstN |=> (!rstN || !selPin));

  // R2
  busy_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    txBusy |=> selPin);

  // R8
  idle_pin_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    idlePin);

  // R9
  fall_on_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(selPin) && $stable(useDtr)) |-> ($past(baudTick) && !$past(txBusy)));

endmodule

bind rs485_dir_timer rs485_dir_timer_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .baudTick(baudTick),
  .txBusy  (txBusy),
  .useDtr  (useDtr),
  .rtsOut  (rtsOut),
  .dtrOut  (dtrOut)
);

// File: tb/test_rs485_dir_timer.sv
module test_rs485_dir_timer;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       baudTick = 1'b0;
  logic       txBusy = 1'b0;
  logic [1:0] sampleSel = 2'b00;
  logic [7:0] delayBits = 8'd1;
  logic       useDtr = 1'b0;
  logic       rtsOut, dtrOut;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  string curReq = "R1";

  // reference model state: 0 receive, 1 drive, 2 counting
  int mMode = 0;
  int mTicks = 0;
  int mTarget = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rs485_dir_timer i_rs485_dir_timer (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .txBusy(txBusy),
    .sampleSel(sampleSel), .delayBits(delayBits), .useDtr(useDtr),
    .rtsOut(rtsOut), .dtrOut(dtrOut)
  );

  function automatic int factorOf(input logic [1:0] code);
    if (code == 2'b01) return 8;
    if (code == 2'b10) return 4;
    return 16;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      mMode = 0;
    end else if (txBusy) begin
      mMode = 1;
    end else if (mMode == 1) begin
      mMode = 2;
      mTicks = 0;
      mTarget = factorOf(sampleSel) * ((delayBits == 0) ? 1 : int'(delayBits));
    end else if (mMode == 2 && baudTick) begin
      mTicks++;
      if (mTicks == mTarget) mMode = 0;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN) begin
      check({curReq, " rts"}, int'(rtsOut), useDtr ? 1 : int'(mMode != 0));
      check({curReq, " dtr"}, int'(dtrOut), useDtr ? int'(mMode != 0) : 1);
    end
    if (cycles > WATCHDOG) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", cycles, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic logic selPin();
    return useDtr ? dtrOut : rtsOut;
  endfunction

  // drive a frame, drop busy, feed ticks every gap cycles, return ticks seen
  task automatic frame(input int busyLen, input int gap, output int ticks);
    int phase = 0;
    txBusy = 1'b1;
    baudTick = 1'b0;
    repeat (busyLen) @(negedge clk);
    txBusy = 1'b0;
    ticks = 0;
    forever begin
      @(negedge clk);
      if (!selPin()) break;
      phase++;
      baudTick = (phase % gap == 0);
      if (baudTick) ticks++;
    end
    baudTick = 1'b0;
  endtask

  task automatic measure(input string req, input logic [1:0] sel, input logic [7:0] dly,
                         input logic dtr, input int gap);
    int ticks;
    curReq = req;
    sampleSel = sel;
    delayBits = dly;
    useDtr = dtr;
    @(negedge clk);
    frame(3, gap, ticks);
    check(req, ticks, factorOf(sel) * ((dly == 0) ? 1 : int'(dly)));
  endtask

  initial begin
    int ticks;
    repeat (3) @(negedge clk);
    curReq = "R1";
    check("R1 sel", int'(rtsOut), 0);
    check("R1 unsel", int'(dtrOut), 1);
    rstN = 1'b1;
    @(negedge clk);

    // R2: busy raises the line next edge and holds it
    curReq = "R2";
    txBusy = 1'b1;
    @(negedge clk);
    check("R2 rise", int'(rtsOut), 1);
    repeat (20) @(negedge clk);
    check("R2 hold", int'(rtsOut), 1);
    txBusy = 1'b0;
    repeat (40) @(negedge clk);

    measure("R3 R4 rate16", 2'b00, 8'd3, 1'b0, 1);
    measure("R4 rate8", 2'b01, 8'd2, 1'b0, 2);
    measure("R4 rate4", 2'b10, 8'd5, 1'b0, 3);
    measure("R5 reserved", 2'b11, 8'd2, 1'b0, 1);
    measure("R6 zero", 2'b01, 8'd0, 1'b0, 1);
    measure("R6 one", 2'b10, 8'd1, 1'b0, 2);
    measure("R8 dtr", 2'b10, 8'd3, 1'b1, 1);
    curReq = "R8";
    check("R8 rts parked", int'(rtsOut), 1);
    measure("R9 sparse ticks", 2'b10, 8'd2, 1'b0, 5);

    // R7: abort in mid bit period, then a fresh full count
    curReq = "R7";
    sampleSel = 2'b10; delayBits = 8'd2; useDtr = 1'b0;
    txBusy = 1'b1;
    repeat (2) @(negedge clk);
    txBusy = 1'b0;
    repeat (6) begin
      @(negedge clk);
      baudTick = ~baudTick;
    end
    baudTick = 1'b0;
    txBusy = 1'b1;
    @(negedge clk);
    check("R7 still driving", int'(rtsOut), 1);
    frame(2, 1, ticks);
    check("R7 fresh count", ticks, 8);

    // R10: settings changed mid countdown are ignored
    curReq = "R10";
    sampleSel = 2'b10; delayBits = 8'd3;
    txBusy = 1'b1;
    repeat (2) @(negedge clk);
    txBusy = 1'b0;
    @(negedge clk);
    sampleSel = 2'b00; delayBits = 8'd9;
    ticks = 0;
    forever begin
      @(negedge clk);
      if (!rtsOut) break;
      baudTick = 1'b1;
      ticks++;
    end
    baudTick = 1'b0;
    check("R10 captured settings", ticks, 12);

    repeat (5) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule